// File: doc/BRIEF.md
# Disk Sector Byte Stream Generator

This block builds the complete byte stream for one sector as it is written to the disk surface. A one-cycle start strobe captures four identification bytes and a flag that marks the first sector of a track. The block then sends the whole sector as a stream of bytes over a valid/ready output, one byte in each cycle that the consumer accepts.

The stream has a fixed order. An optional track preamble comes first. Then come the gap fields, the identification mark, the four ID bytes and their two check bytes, a short zero gap, the data mark, and the payload. The payload is taken byte by byte from a valid/ready input. The sector closes with a trailing gap.

When the payload source has no byte ready, the output pauses and no position in the stream is skipped. A one-cycle done pulse follows acceptance of the final byte. While a sector is in progress, further start strobes are ignored.

Top module: `sector_stream_gen`

## Requirements
- R1: After reset, `busy`, `done`, `out_valid` and `in_ready` are all low.
- R2: When `first_i` is 1 at the start strobe, the stream opens with 11 bytes of 00h, then the bytes A1h and FCh, in that order.
- R3: When `first_i` is 0 at the start strobe, the first byte sent is the first FFh of the 12-byte FFh gap, and no preamble is sent.
- R4: After the preamble (if sent), the stream carries these fields in order: 12 bytes FFh, 10 bytes 00h, the ID mark 5Eh then A1h. After the check bytes it carries 5 bytes 00h, then the data mark 5Eh then A1h.
- R5: The four bytes after the ID mark are track, head, sector and status, in that order, as captured at the start strobe.
- R6: The two bytes after the ID bytes are a CRC-16 over the four ID bytes, sent high byte first. The CRC uses polynomial 1021h, starts from FFFFh, feeds each byte MSB first, and has no final inversion.
- R7: The payload is exactly 512 bytes, passed through unchanged and in arrival order. `in_ready` is high only during the payload and only while `out_ready` is high.
- R8: During the payload, when `in_valid` is low, `out_valid` is low and the stream does not advance.
- R9: The sector ends with 3 bytes of 00h and then 17 bytes of FFh. The total length is 582 bytes with the preamble and 569 bytes without it.
- R10: `done` is high for exactly one cycle, in the cycle after the last FFh is accepted. In that cycle `busy` is already low.
- R11: A start strobe that arrives while `busy` is high has no effect on the stream in progress.
- R12: Outside the payload, a byte offered while `out_ready` is low stays offered with the same value until it is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin a sector |
| first_i | input | 1 | Sector is the first of its track (add preamble) |
| trk_i | input | 8 | Track number |
| hd_i | input | 8 | Head number |
| sec_i | input | 8 | Sector number |
| stat_i | input | 8 | Sector status byte |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte available |
| in_ready | output | 1 | Payload byte taken this cycle |
| out_data | output | 8 | Stream byte |
| out_valid | output | 1 | Stream byte available |
| out_ready | input | 1 | Consumer takes the stream byte |
| busy | output | 1 | Sector in progress |
| done | output | 1 | One-cycle end-of-sector pulse |

## Verification
The byte-hold property holds only outside the payload, because it assumes the upstream source can withdraw `in_valid` at any time. The payload check likewise assumes `in_data` is meaningful only while `in_valid` is high.

The bench drives `in_valid`, `in_data` and `out_ready` only at falling edges, from a pseudo-random sequence. Several sectors cover each combination of a steady or stalling consumer and a steady or stalling source, with and without the preamble. ID values include 00h and FFh. One sector receives a stray start strobe with different ID values while it is running.

// File: rtl/sector_stream_gen.sv
module sector_stream_gen #(
  parameter int DATA_LEN = 512,
  parameter int PRE_LEN  = 11,
  parameter int GAP_FF   = 12,
  parameter int GAP_ZA   = 10,
  parameter int GAP_ZB   = 5,
  parameter int TAIL_Z   = 3,
  parameter int TAIL_FF  = 17
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       first_i,
  input  logic [7:0] trk_i,
  input  logic [7:0] hd_i,
  input  logic [7:0] sec_i,
  input  logic [7:0] stat_i,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  output logic [7:0] out_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic       busy,
  output logic       done
);
  localparam int MAXL = (DATA_LEN > 32) ? DATA_LEN : 32;
  localparam int CW   = $clog2(MAXL);

  typedef enum logic [3:0] {
    S_PRE, S_MK, S_GFF, S_GZ, S_AM, S_ID, S_CRC, S_Z5, S_DM, S_DAT, S_TZ, S_TF
  } seg_t;

  seg_t          seg;
  logic [CW-1:0] cnt;
  logic [31:0]   id_q;
  logic [15:0]   crc;
  logic          acc, last;

  function automatic logic [CW-1:0] seg_last(input seg_t s);
    case (s)
      S_PRE:                   seg_last = CW'(PRE_LEN - 1);
      S_MK, S_AM, S_CRC, S_DM: seg_last = CW'(1);
      S_GFF:                   seg_last = CW'(GAP_FF - 1);
      S_GZ:                    seg_last = CW'(GAP_ZA - 1);
      S_ID:                    seg_last = CW'(3);
      S_Z5:                    seg_last = CW'(GAP_ZB - 1);
      S_DAT:                   seg_last = CW'(DATA_LEN - 1);
      S_TZ:                    seg_last = CW'(TAIL_Z - 1);
      default:                 seg_last = CW'(TAIL_FF - 1);
    endcase
  endfunction

  function automatic logic [15:0] crc16(input logic [31:0] bits);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int i = 31; i >= 0; i--)
      c = {c[14:0], 1'b0} ^ ((c[15] ^ bits[i]) ? 16'h1021 : 16'h0000);
    return c;
  endfunction

  assign crc       = crc16(id_q);
  assign last      = (cnt == seg_last(seg));
  assign out_valid = busy && (seg != S_DAT || in_valid);
  assign in_ready  = busy && seg == S_DAT && out_ready;
  assign acc       = out_valid && out_ready;

  always_comb begin
    case (seg)
      S_MK:         out_data = (cnt == '0) ? 8'hA1 : 8'hFC;
      S_GFF, S_TF:  out_data = 8'hFF;
      S_AM, S_DM:   out_data = (cnt == '0) ? 8'h5E : 8'hA1;
      S_ID:         out_data = id_q[8'(31 - 8 * cnt[1:0]) -: 8];
      S_CRC:        out_data = (cnt == '0) ? crc[15:8] : crc[7:0];
      S_DAT:        out_data = in_data;
      default:      out_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      seg  <= S_PRE;
      cnt  <= '0;
      id_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start_i) begin
          busy <= 1'b1;
          seg  <= first_i ? S_PRE : S_GFF;
          cnt  <= '0;
          id_q <= {trk_i, hd_i, sec_i, stat_i};
        end
      end else if (acc) begin
        if (!last) begin
          cnt <= cnt + 1'b1;
        end else begin
          cnt <= '0;
          if (seg == S_TF) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            seg <= seg_t'(seg + 4'd1);
          end
        end
      end
    end
  end

  // R12
  hold_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && seg != S_DAT |=> out_valid && $stable(out_data));
  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && seg == S_DAT && !in_valid |=> seg == S_DAT && cnt == $past(cnt));
  // R7
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && in_valid |-> acc && out_data == in_data);
  // R11
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start_i |=> $stable(id_q));
endmodule

// File: tb/test_sector_stream_gen.sv
module test_sector_stream_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, first_i = 0;
  logic [7:0] trk_i = 0, hd_i = 0, sec_i = 0, stat_i = 0, in_data = 0;
  logic in_valid = 0, out_ready = 0;
  logic in_ready, out_valid, busy, done;
  logic [7:0] out_data;

  int errors = 0, checks = 0, cycles = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  sector_stream_gen i_sector_stream_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .first_i(first_i),
    .trk_i(trk_i), .hd_i(hd_i), .sec_i(sec_i), .stat_i(stat_i),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .busy(busy), .done(done));

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [7:0] b0, b1, b2, b3);
    logic [15:0] c = 16'hFFFF;
    logic [7:0] bs[4] = '{b0, b1, b2, b3};
    foreach (bs[j]) begin
      c = c ^ {bs[j], 8'h00};
      for (int k = 0; k < 8; k++)
        c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return c;
  endfunction

  function automatic logic [7:0] dpat(input int seed, input int i);
    return 8'((i * 13 + seed) ^ (i >> 8));
  endfunction

  // full offsets assume the preamble; non-first sectors are shifted by 13
  function automatic logic [7:0] exp_at(input int k, input logic [7:0] t, h, s, st,
                                        input logic [15:0] c, input int seed);
    if (k < 11) return 8'h00;
    if (k == 11) return 8'hA1;
    if (k == 12) return 8'hFC;
    if (k < 25) return 8'hFF;
    if (k < 35) return 8'h00;
    if (k == 35 || k == 48) return 8'h5E;
    if (k == 36 || k == 49) return 8'hA1;
    if (k == 37) return t;
    if (k == 38) return h;
    if (k == 39) return s;
    if (k == 40) return st;
    if (k == 41) return c[15:8];
    if (k == 42) return c[7:0];
    if (k < 48) return 8'h00;
    if (k < 562) return dpat(seed, k - 50);
    if (k < 565) return 8'h00;
    return 8'hFF;
  endfunction

  function automatic string req_at(input int k, input bit first);
    if (k < 13) return "R2";
    if (k == 13 && !first) return "R3";
    if (k < 37) return "R4";
    if (k < 41) return "R5";
    if (k < 43) return "R6";
    if (k < 50) return "R4";
    if (k < 562) return "R7";
    return "R9";
  endfunction

  task automatic run_sector(input bit first, input logic [7:0] t, h, s, st,
                            input int seed, input int rmode, input bit inject);
    int len = first ? 582 : 569;
    int off = first ? 0 : 13;
    int n = 0, dptr = 0, cyc = 0;
    int stall_bad = 0, rdy_bad = 0, early = 0, hold_bad = 0, err0;
    bit hold_pend = 0;
    logic [7:0] hold_val = 0;
    logic [15:0] c = ref_crc(t, h, s, st);
    bit in_dat;
    err0 = errors;
    @(negedge clk);
    start_i = 1; first_i = first; trk_i = t; hd_i = h; sec_i = s; stat_i = st;
    @(negedge clk);
    start_i = 0;
    while (n < len && cyc < 6000) begin
      out_ready = rmode[0] ? lfsr[0] : 1'b1;
      in_valid  = rmode[1] ? (lfsr[3] | lfsr[7]) : 1'b1;
      in_data   = dpat(seed, dptr);
      if (inject && cyc == 40) begin
        start_i = 1; first_i = ~first; trk_i = ~t; hd_i = ~h; sec_i = ~s; stat_i = ~st;
      end else start_i = 0;
      #1;
      in_dat = (n + off >= 50) && (n + off < 562);
      if (hold_pend && !(out_valid && out_data == hold_val)) hold_bad++;
      if (done) early++;
      if (in_dat && !in_valid && out_valid) stall_bad++;
      if (in_ready && !(in_dat && out_ready)) rdy_bad++;
      hold_pend = out_valid && !out_ready && !in_dat;
      hold_val  = out_data;
      if (out_valid && out_ready) begin
        if (out_data !== exp_at(n + off, t, h, s, st, c, seed))
          chk(0, req_at(n + off, first), out_data, exp_at(n + off, t, h, s, st, c, seed));
        else checks++;
        n++;
      end
      if (in_valid && in_ready) dptr++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc++;
      @(negedge clk);
    end
    in_valid = 0;
    out_ready = 0;
    #1;
    chk(n == len, "R9 length", n, len);
    chk(dptr == 512, "R7 payload count", dptr, 512);
    chk(stall_bad == 0, "R8 stall", stall_bad, 0);
    chk(rdy_bad == 0, "R7 in_ready", rdy_bad, 0);
    chk(hold_bad == 0, "R12 hold", hold_bad, 0);
    chk(early == 0, "R10 early done", early, 0);
    chk(done == 1 && busy == 0, "R10 done pulse", {done, busy}, 2);
    @(negedge clk); #1;
    chk(done == 0, "R10 done width", done, 0);
    if (inject) chk(errors == err0, "R11 start while busy", errors - err0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !done && !out_valid && !in_ready, "R1 reset",
        {busy, done, out_valid, in_ready}, 0);
    rst_n = 1;
    @(negedge clk); #1;
    chk(!busy && !done && !out_valid, "R1 idle", {busy, done, out_valid}, 0);
    for (int sx = 0; sx < 8; sx++)
      run_sector(sx[0], 8'(sx * 37), 8'(sx), 8'(8'hFF - sx * 3), 8'(sx * 5),
                 sx * 11, sx >> 1, sx == 5);
    run_sector(1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 3, 3, 1'b0);
    run_sector(1'b1, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 7, 1, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule